// File: doc/BRIEF.md
# Two-channel prescaled PWM controller

This block is a pulse-width modulation peripheral with two independent output channels. Software programs it through a simple 32-bit register bus. Writes complete in one cycle with no wait states. Reads are combinational on the address.

One control word holds a 10-bit field group for each channel. The group for channel n starts at bit 15*n. Each channel also has a period/duty register. The prescaled clock tick drives a per-channel counter that sets the period and the active time. A new period/duty value waits in a shadow register until the channel reaches a period boundary. While it waits, a per-channel busy flag reads 1 in the control word.

Each channel is a four-state machine:
- **Stopped** moves to **Running**, or to **Armed** when the mode bit is set, once enable and clock gate are both 1.
- **Running** returns to **Stopped** when the channel loses enable or gate. It moves to **Armed** when the mode bit is set.
- **Armed** moves to **Shot** when the pulse bit is set. It moves to **Running** when the mode bit clears, and to **Stopped** when the channel loses enable or gate.
- **Shot** returns to **Armed** at the end of its single period. It moves to **Stopped** when the channel loses enable or gate.

Top module: `pwm2_ctrl`

## Requirements
- R1: The control word is at byte address 0x0. Channel n's period/duty register is at 0x4 + 4*n, and reading it returns the value last written there.
- R2: Field group n sits at bits [15n+9:15n], laid out as follows: [3:0] prescaler code, bit 4 enable, bit 5 active level, bit 6 clock gate, bit 7 mode, bit 8 pulse, bit 9 bypass (stored only). Bits 28+n are read-only busy flags. Bits 10–14, 25–27 and 30–31 read 0.
- R3: The prescaler code selects the input-clock divider. Codes 0–4 give 120, 180, 240, 360 and 480. Codes 8–12 give 12000, 24000, 36000, 48000 and 72000. Code 15 gives 1.
- R4: Codes 5–7, 13 and 14 hold the prescaler in reset with no ticks, so the channel's counter and output stay frozen.
- R5: A running channel repeats a period of P+1 ticks, where P is bits [31:16] of its period/duty register. The output is active for the first D ticks of each period, where D is bits [15:0].
- R6: D = 0 gives a constantly inactive output. D > P gives a constantly active output.
- R7: An active-level bit of 1 makes the output active high. A 0 makes it active low.
- R8: A channel runs only while both its enable and clock-gate bits are 1. Otherwise its output rests at the inactive level.
- R9: A write to a period/duty register sets that channel's busy flag from the next cycle. The value is applied, and the flag cleared, at the next period boundary. If the channel is not counting, this happens on the following clock.
- R10: With the mode bit set, a channel rests inactive until the pulse bit is written 1. It then outputs exactly one period, and hardware clears the pulse bit when that period ends.
- R11: After reset the control word reads 0 and both outputs are high, which is the inactive level of active-low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pwm_out | output | 2 | Channel outputs |

## Verification
The assertions assume the following about the inputs:
- Software does not rewrite a period/duty register while its busy flag is set.
- Writes go only to the three mapped addresses.
- The pulse bit is cleared only through a control write or the end of a shot.

The stimulus keeps within these limits in two ways. It polls the busy flag before each reprogramming. It also stops a channel, through a control write of zero, before loading a new period/duty value.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
    localparam int NCH      = 2;
    localparam int DATA_W   = 32;
    localparam int CNT_W    = DATA_W / 2;
    localparam int STRIDE   = 15;
    localparam int FLD_W    = 10;
    localparam int RDY_BASE = 28;
    localparam int DIV_W    = 17;

    // Field group, prescaler code in the low bits.
    typedef struct packed {
        logic       bypass;
        logic       pulse;
        logic       mode;
        logic       gate;
        logic       level;
        logic       en;
        logic [3:0] code;
    } chan_ctl_t;

    typedef enum logic [1:0] {ST_STOP, ST_RUN, ST_ARMED, ST_SHOT} chan_st_t;

    // Divider for a prescaler code; zero marks an unused code.
    function automatic logic [DIV_W-1:0] code_div(input logic [3:0] c);
        logic [DIV_W-1:0] d;
        case (c)
            4'd0:    d = DIV_W'(120);
            4'd1:    d = DIV_W'(180);
            4'd2:    d = DIV_W'(240);
            4'd3:    d = DIV_W'(360);
            4'd4:    d = DIV_W'(480);
            4'd8:    d = DIV_W'(12000);
            4'd9:    d = DIV_W'(24000);
            4'd10:   d = DIV_W'(36000);
            4'd11:   d = DIV_W'(48000);
            4'd12:   d = DIV_W'(72000);
            4'd15:   d = DIV_W'(1);
            default: d = '0;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/pwm2_presc.sv
module pwm2_presc
    import pwm2_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [3:0] code,
    output logic       tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] div, lim, cnt;
    logic             live;

    assign div  = code_div(code);
    assign lim  = div - ONE;
    assign live = run && (div != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!live || cnt >= lim)
            cnt <= '0;
        else
            cnt <= cnt + ONE;
    end

    assign tick = live && (cnt >= lim);
endmodule

// File: rtl/pwm2_chan.sv
module pwm2_chan
    import pwm2_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               mode,
    input  logic               pulse,
    input  logic               level,
    input  logic               tick,
    input  logic               pd_wr,
    input  logic [2*CNT_W-1:0] pd_wdata,
    output logic [2*CNT_W-1:0] pd_rd,
    output logic               pend,
    output logic               shot_done,
    output logic               pwm_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    chan_st_t         st, st_nx;
    logic [CNT_W-1:0] cnt, prd, dty, prd_sh, dty_sh;
    logic             wrap, counting, apply, act;

    assign counting = (st == ST_RUN) || (st == ST_SHOT);
    assign wrap     = counting && tick && (cnt == prd);
    assign apply    = pend && (!counting || wrap);
    assign pd_rd    = {prd_sh, dty_sh};

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_STOP:  if (run) st_nx = mode ? ST_ARMED : ST_RUN;
            ST_RUN:   if (!run) st_nx = ST_STOP;
                      else if (mode) st_nx = ST_ARMED;
            ST_ARMED: if (!run) st_nx = ST_STOP;
                      else if (!mode) st_nx = ST_RUN;
                      else if (pulse) st_nx = ST_SHOT;
            ST_SHOT:  if (!run) st_nx = ST_STOP;
                      else if (wrap) st_nx = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_STOP;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            prd    <= '0;
            dty    <= '0;
            prd_sh <= '0;
            dty_sh <= '0;
            pend   <= 1'b0;
        end else begin
            if (st_nx != st || !counting || wrap) cnt <= '0;
            else if (tick)                         cnt <= cnt + ONE;
            if (pd_wr) begin
                prd_sh <= pd_wdata[2*CNT_W-1:CNT_W];
                dty_sh <= pd_wdata[CNT_W-1:0];
            end
            if (apply) begin
                prd <= prd_sh;
                dty <= dty_sh;
            end
            if (pd_wr)      pend <= 1'b1;
            else if (apply) pend <= 1'b0;
        end
    end

    always_comb begin
        act       = counting && (cnt < dty);
        pwm_o     = level ? act : !act;
        shot_done = (st == ST_SHOT) && wrap && run;
    end
endmodule

// File: rtl/pwm2_ctrl.sv
module pwm2_ctrl
    import pwm2_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCH-1:0]    pwm_out
);
    localparam logic [ADDR_W-1:0] A_CTRL = '0;

    logic [NCH-1:0][FLD_W-1:0]  ctl_q;
    logic [NCH-1:0][DATA_W-1:0] pd_q;
    logic [NCH-1:0]             run_q, tick, pend, shot_done;
    logic                       ctrl_wr;

    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        chan_ctl_t          ctl_r;
        logic               pd_wr;
        logic [2*CNT_W-1:0] pd_rd;

        assign pd_wr = bus_wr && (bus_addr == ADDR_W'(4 * (g + 1)));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ctl_r <= '0;
            else if (ctrl_wr)
                ctl_r <= chan_ctl_t'(bus_wdata[STRIDE*g +: FLD_W]);
            else if (shot_done[g])
                ctl_r.pulse <= 1'b0;
        end

        assign ctl_q[g] = ctl_r;
        assign run_q[g] = ctl_r.en && ctl_r.gate;
        assign pd_q[g]  = DATA_W'(pd_rd);

        pwm2_presc u_presc (
            .clk  (clk),
            .rst_n(rst_n),
            .run  (run_q[g]),
            .code (ctl_r.code),
            .tick (tick[g])
        );

        pwm2_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_q[g]),
            .mode     (ctl_r.mode),
            .pulse    (ctl_r.pulse),
            .level    (ctl_r.level),
            .tick     (tick[g]),
            .pd_wr    (pd_wr),
            .pd_wdata (bus_wdata[2*CNT_W-1:0]),
            .pd_rd    (pd_rd),
            .pend     (pend[g]),
            .shot_done(shot_done[g]),
            .pwm_o    (pwm_out[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL) begin
            for (int i = 0; i < NCH; i++) begin
                bus_rdata[STRIDE*i +: FLD_W] = ctl_q[i];
                bus_rdata[RDY_BASE + i]      = pend[i];
            end
        end else begin
            for (int i = 0; i < NCH; i++)
                if (bus_addr == ADDR_W'(4 * (i + 1))) bus_rdata = pd_q[i];
        end
    end
endmodule

// File: rtl/pwm2_ctrl_chk.sv
module pwm2_ctrl_chk
    import pwm2_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_wr,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [31:0]               bus_rdata,
    input logic [NCH-1:0][FLD_W-1:0] ctl_q,
    input logic [NCH-1:0]            run_q,
    input logic [NCH-1:0]            tick,
    input logic [NCH-1:0]            pend,
    input logic [NCH-1:0]            pwm_out
);
    function automatic logic [31:0] zero_mask();
        logic [31:0] m = '1;
        for (int i = 0; i < NCH; i++) begin
            m[STRIDE*i +: FLD_W] = '0;
            m[RDY_BASE + i]      = 1'b0;
        end
        return m;
    endfunction
    localparam logic [31:0] ZMASK = zero_mask();

    // R2: reserved control bits read zero
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> ((bus_rdata & ZMASK) == '0));

    for (genvar g = 0; g < NCH; g++) begin : g_a
        // R8: a channel stopped for two cycles sits at its inactive level
        p_stop_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(run_q[g]) && !run_q[g]) |-> (pwm_out[g] == !ctl_q[g][5]));
        // R9: a period/duty write raises the busy flag
        p_busy_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(4 * (g + 1))) |=> pend[g]);
        // R4: unused prescaler codes produce no tick
        p_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (code_div(ctl_q[g][3:0]) == '0) |-> !tick[g]);
        // R10: when hardware clears the pulse bit the output is inactive
        p_shot_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(ctl_q[g][8]) && !$past(bus_wr && bus_addr == '0))
            |-> (pwm_out[g] == !ctl_q[g][5]));
    end
endmodule

bind pwm2_ctrl pwm2_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .ctl_q    (ctl_q),
    .run_q    (run_q),
    .tick     (tick),
    .pend     (pend),
    .pwm_out  (pwm_out)
);

// File: tb/pwm2_ctrl_bench.sv
module pwm2_ctrl_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  pwm_out;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pwm2_ctrl u_pwm2_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    typedef struct packed {
        int ch; int prd; int dty; int pol; int exp_hi;
    } vec_t;
    // High cycles over four periods with divide-by-one (R5, R6, R7)
    localparam vec_t VEC [7] = '{
        '{0, 9, 3, 1, 12},   // R5 basic
        '{0, 9, 0, 1, 0},    // R6 zero duty
        '{0, 9, 12, 1, 40},  // R6 duty above period
        '{0, 4, 2, 0, 12},   // R7 active low
        '{0, 0, 1, 1, 4},    // R5 single-tick period
        '{1, 7, 8, 1, 32},   // R6 duty equals period length
        '{1, 5, 2, 0, 16}    // R7 channel 1 active low
    };

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic count_high(input int ch, input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[ch]) hi++;
        end
    endtask

    function automatic logic [31:0] ctl(input int ch, input logic [9:0] f);
        return 32'(f) << (15 * ch);
    endfunction

    initial begin
        #(CLK_P * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int hi;
        int waited;
        // R11: reset state
        repeat (3) @(negedge clk);
        bus_read(4'h0, rd);
        check(rd == 0, "R11 ctrl", rd, 0);
        check(pwm_out == 2'b11, "R11 out", pwm_out, 3);
        rst_n = 1'b1;

        // R1: period/duty readback
        bus_write(4'h4, 32'h1234_5678);
        bus_write(4'h8, 32'hCAFE_0001);
        bus_read(4'h4, rd);
        check(rd == 32'h1234_5678, "R1 ch0 reg", rd, 32'h1234_5678);
        bus_read(4'h8, rd);
        check(rd == 32'hCAFE_0001, "R1 ch1 reg", rd, 32'hCAFE_0001);

        // R2: only field groups store; busy bits unaffected by writes
        bus_write(4'h0, 32'hFFFF_FFFF);
        bus_read(4'h0, rd);
        check(rd == 32'h01FF_83FF, "R2 ctrl mask", rd, 32'h01FF_83FF);
        bus_write(4'h0, 32'h0);

        // R5/R6/R7 table
        foreach (VEC[k]) begin
            bus_write(4'h0, 32'h0);
            bus_write(4'(4 * (VEC[k].ch + 1)), {16'(VEC[k].prd), 16'(VEC[k].dty)});
            repeat (3) @(negedge clk);
            bus_write(4'h0, ctl(VEC[k].ch, 10'h05F | (10'(VEC[k].pol) << 5)));
            repeat (4) @(negedge clk);
            count_high(VEC[k].ch, 4 * (VEC[k].prd + 1), hi);
            check(hi == VEC[k].exp_hi, "R5 table", hi, VEC[k].exp_hi);
        end

        // R3: code 0 divides by 120; P=1 D=1 gives 120 high per 240
        bus_write(4'h0, 32'h0);
        bus_write(4'h4, {16'd1, 16'd1});
        bus_write(4'h0, ctl(0, 10'h070));
        repeat (300) @(negedge clk);
        count_high(0, 480, hi);
        check(hi == 240, "R3 div120", hi, 240);

        // R4: unused code 5 freezes the counter (output stays active)
        bus_write(4'h0, 32'h0);
        bus_write(4'h4, {16'd3, 16'd2});
        bus_write(4'h0, ctl(0, 10'h075));
        repeat (4) @(negedge clk);
        count_high(0, 50, hi);
        check(hi == 50, "R4 frozen", hi, 50);

        // R8: enable without gate, gate without enable, then stop active-low
        bus_write(4'h0, ctl(0, 10'h03F));
        repeat (3) @(negedge clk);
        count_high(0, 40, hi);
        check(hi == 0, "R8 no gate", hi, 0);
        bus_write(4'h0, ctl(0, 10'h06F));
        repeat (3) @(negedge clk);
        count_high(0, 40, hi);
        check(hi == 0, "R8 no enable", hi, 0);
        bus_write(4'h0, ctl(0, 10'h00F));
        repeat (2) @(negedge clk);
        check(pwm_out[0] == 1'b1, "R8 idle low-active", pwm_out[0], 1);

        // R9: busy flag while running, applied at boundary
        bus_write(4'h0, 32'h0);
        bus_write(4'h4, {16'd99, 16'd10});
        bus_write(4'h0, ctl(0, 10'h07F));
        repeat (10) @(negedge clk);
        bus_write(4'h4, {16'd99, 16'd50});
        bus_read(4'h0, rd);
        check(rd[28] == 1'b1, "R9 busy set", rd[28], 1);
        waited = 0;
        while (rd[28] && waited < 120) begin
            @(negedge clk);
            bus_read(4'h0, rd);
            waited++;
        end
        check(rd[28] == 1'b0, "R9 busy cleared", rd[28], 0);
        count_high(0, 200, hi);
        check(hi == 100, "R9 new duty", hi, 100);
        bus_write(4'h0, 32'h0);
        bus_write(4'h8, {16'd5, 16'd1});
        @(negedge clk);
        bus_read(4'h0, rd);
        check(rd[29] == 1'b0, "R9 stopped apply", rd[29], 0);

        // R10: single pulse
        bus_write(4'h4, {16'd9, 16'd4});
        repeat (3) @(negedge clk);
        bus_write(4'h0, ctl(0, 10'h0FF));
        repeat (3) @(negedge clk);
        count_high(0, 20, hi);
        check(hi == 0, "R10 armed idle", hi, 0);
        bus_write(4'h0, ctl(0, 10'h1FF));
        count_high(0, 40, hi);
        check(hi == 4, "R10 one shot", hi, 4);
        bus_read(4'h0, rd);
        check(rd[8] == 1'b0, "R10 pulse cleared", rd[8], 0);
        bus_write(4'h0, ctl(0, 10'h1FF));
        count_high(0, 40, hi);
        check(hi == 4, "R10 second shot", hi, 4);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule